// File: doc/BRIEF.md
# External Interrupt Line Controller

This block turns pin activity from a set of general-purpose I/O ports into interrupt requests on sixteen independent lines. Every line chooses one port as its source through a 4-bit selector field, passes that pin through a two-flop synchroniser, and watches it for a rising edge, a falling edge, or both. A detected event latches a pending flag, which software removes by writing a one to it. Software may also raise a flag directly. A per-line enable (mask) decides whether a pending flag reaches the interrupt outputs. Lines 0 to 4 each own an output, while lines 5 to 9 and lines 10 to 15 are merged onto two shared outputs.

A line may also be put in level mode. In that mode the flag keeps coming back for as long as the selected pin sits at the active level, which is high when the line's rising enable is set and low otherwise. This covers a pin that is already active when the line is configured. A build parameter chooses one of two pending layouts. The first is a single flag per line. The second is a pair of flags per line, one for rising events and one for falling events, each cleared on its own. The line's request is the OR of the pair.

Software reaches all state through a single-cycle word register port with a combinational read.

Top module: `extint_ctrl`

## Requirements
- R1: Only bits 15:0 of the mask, rising-enable, falling-enable, level-mode and pending registers hold state. Bits 31:16 of every register at word address 0 to 7 read as zero, even after ones are written there.
- R2: With only the rising enable of a line set (address 1, bit = line), a 0-to-1 change on its source sets the flag. With only the falling enable set (address 2), a 1-to-0 change sets it. With both set, either change sets it. With neither set, no pin change sets it.
- R3: Writing to address 4 clears every pending bit whose written data bit is 1 and leaves the bits written as 0 unchanged. No pending bit is ever cleared without such a write.
- R4: With SPLIT_PENDING=1, rising events set a flag readable at address 5 and falling events set one at address 6. Each is cleared by writing 1 to its own address. Address 4 reads the OR of both and clears both. With SPLIT_PENDING=0, addresses 5 and 6 read zero and writes to them are ignored.
- R5: Writing 1s to address 3 sets the matching pending flags in the next cycle, whatever the mask and trigger settings are. In split mode these go to the rising flags. Address 3 reads zero.
- R6: A line drives an interrupt output only while its pending flag is set and its mask bit (address 0) is 1. A mask of zero forces every output low in the cycle after the write.
- R7: The source of line L is the 4-bit field at bits [8*(L%4)+3 : 8*(L%4)] of the selector register at address 8 + (L>>2). Bits [8*k+7 : 8*k+4] of that register read as zero. Activity on ports other than the selected one has no effect on the line.
- R8: Output bit k is driven by line k for k = 0..4. Output bit 5 is the OR of lines 5 to 9, and output bit 6 is the OR of lines 10 to 15.
- R9: When the level bit of a line is set (address 7), its pending flag is set in every cycle in which the synchronised source equals the active level (the rising-enable bit value). A clear written while the pin is still active therefore has no lasting effect.
- R10: A pin change made between clock edges becomes visible in the pending flag after the third rising clock edge and not after the second.
- R11: If a hardware set and a write-1 clear reach the same flag in the same cycle, the flag stays set.
- R12: After reset every register reads zero and all interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| portPins | input | NUM_PORTS x 16 | Pin levels, portPins[p][l] is pin l of port p |
| irqOut | output | 7 | Grouped interrupt requests |

## Verification
The assertions watch, on every cycle, the rules that can be stated as relations over time. A pending flag may drop only after a clear write. A software trigger always leaves its flags set. No output is raised by a masked or idle line, in each of the three groupings. An all-zero mask silences the outputs, and the reserved upper read bits stay zero. Edge polarity selection, the three-edge latency, port selection through the packed fields, level re-arming, set-over-clear priority and the split flag layout depend on particular pin histories. Only the bench's directed and random scenarios can show these.

// File: rtl/extint_pkg.sv
package extint_pkg;

  localparam int LINES      = 16;
  localparam int LINE_W     = $clog2(LINES);
  localparam int DATA_W     = 32;
  localparam int SEL_W      = 4;
  localparam int SEL_STRIDE = 8;
  localparam int FIELDS     = DATA_W / SEL_STRIDE;
  localparam int SEL_REGS   = LINES / FIELDS;
  localparam int SELREG_W   = $clog2(SEL_REGS);
  localparam int ADDR_W     = 4;
  localparam int SOLO_LINES = 5;
  localparam int MID_END    = 10;
  localparam int NUM_IRQ    = SOLO_LINES + 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_MASK  = 4'd0,
    REG_RISE  = 4'd1,
    REG_FALL  = 4'd2,
    REG_SWSET = 4'd3,
    REG_PEND  = 4'd4,
    REG_PENDR = 4'd5,
    REG_PENDF = 4'd6,
    REG_LEVEL = 4'd7,
    REG_SEL0  = 4'd8,
    REG_SEL1  = 4'd9,
    REG_SEL2  = 4'd10,
    REG_SEL3  = 4'd11
  } regAddr_e;

  typedef struct packed {
    logic [LINES-1:0] swSet;
    logic [LINES-1:0] clrRise;
    logic [LINES-1:0] clrFall;
  } strobe_t;

  function automatic int lineGroup(input int line);
    if (line < SOLO_LINES) return line;
    else if (line < MID_END) return SOLO_LINES;
    else return SOLO_LINES + 1;
  endfunction

  function automatic logic [LINES-1:0] groupLines(input int grp);
    logic [LINES-1:0] m;
    m = '0;
    for (int l = 0; l < LINES; l++) begin
      if (lineGroup(l) == grp) m[l] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/extint_regs.sv
module extint_regs
  import extint_pkg::*;
#(
  parameter int SPLIT_PENDING = 0
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  input  logic [LINES-1:0]            pendRise,
  input  logic [LINES-1:0]            pendFall,
  output logic [DATA_W-1:0]           rdata,
  output strobe_t                     strobes,
  output logic [LINES-1:0]            maskQ,
  output logic [LINES-1:0]            riseQ,
  output logic [LINES-1:0]            fallQ,
  output logic [LINES-1:0]            levelQ,
  output logic [LINES-1:0][SEL_W-1:0] selQ
);

  regAddr_e regSel;
  logic     splitOn;

  assign regSel  = regAddr_e'(addr);
  assign splitOn = (SPLIT_PENDING != 0);

  // configuration storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ  <= '0;
      riseQ  <= '0;
      fallQ  <= '0;
      levelQ <= '0;
      selQ   <= '0;
    end else if (wrEn) begin
      case (regSel)
        REG_MASK:  maskQ  <= wdata[LINES-1:0];
        REG_RISE:  riseQ  <= wdata[LINES-1:0];
        REG_FALL:  fallQ  <= wdata[LINES-1:0];
        REG_LEVEL: levelQ <= wdata[LINES-1:0];
        REG_SEL0, REG_SEL1, REG_SEL2, REG_SEL3: begin
          for (int f = 0; f < FIELDS; f++) begin
            selQ[LINE_W'(int'(addr[SELREG_W-1:0]) * FIELDS + f)]
              <= wdata[f*SEL_STRIDE +: SEL_W];
          end
        end
        default: ;
      endcase
    end
  end

  // strobes towards the datapath
  always_comb begin
    strobes = '0;
    if (wrEn) begin
      case (regSel)
        REG_SWSET: strobes.swSet = wdata[LINES-1:0];
        REG_PEND: begin
          strobes.clrRise = wdata[LINES-1:0];
          strobes.clrFall = wdata[LINES-1:0];
        end
        REG_PENDR: if (splitOn) strobes.clrRise = wdata[LINES-1:0];
        REG_PENDF: if (splitOn) strobes.clrFall = wdata[LINES-1:0];
        default: ;
      endcase
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    case (regSel)
      REG_MASK:  rdata[LINES-1:0] = maskQ;
      REG_RISE:  rdata[LINES-1:0] = riseQ;
      REG_FALL:  rdata[LINES-1:0] = fallQ;
      REG_LEVEL: rdata[LINES-1:0] = levelQ;
      REG_PEND:  rdata[LINES-1:0] = pendRise | pendFall;
      REG_PENDR: if (splitOn) rdata[LINES-1:0] = pendRise;
      REG_PENDF: if (splitOn) rdata[LINES-1:0] = pendFall;
      REG_SEL0, REG_SEL1, REG_SEL2, REG_SEL3: begin
        for (int f = 0; f < FIELDS; f++) begin
          rdata[f*SEL_STRIDE +: SEL_W] =
            selQ[LINE_W'(int'(addr[SELREG_W-1:0]) * FIELDS + f)];
        end
      end
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/extint_datapath.sv
module extint_datapath
  import extint_pkg::*;
#(
  parameter int NUM_PORTS     = 16,
  parameter int SPLIT_PENDING = 0
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [NUM_PORTS-1:0][LINES-1:0]     portPins,
  input  logic [LINES-1:0][SEL_W-1:0]         selQ,
  input  logic [LINES-1:0]                    maskQ,
  input  logic [LINES-1:0]                    riseQ,
  input  logic [LINES-1:0]                    fallQ,
  input  logic [LINES-1:0]                    levelQ,
  input  strobe_t                             strobes,
  output logic [LINES-1:0]                    pendRise,
  output logic [LINES-1:0]                    pendFall,
  output logic [NUM_IRQ-1:0]                  irqOut
);

  logic [LINES-1:0] rawPin;
  logic [LINES-1:0] syncA;
  logic [LINES-1:0] syncB;
  logic [LINES-1:0] prevQ;
  logic [LINES-1:0] riseEvt;
  logic [LINES-1:0] fallEvt;
  logic [LINES-1:0] levelHit;
  logic [LINES-1:0] activeReq;

  // per-line source selection
  for (genvar l = 0; l < LINES; l++) begin : g_line
    assign rawPin[l] = (int'(selQ[l]) < NUM_PORTS) ? portPins[selQ[l]][l] : 1'b0;
  end

  // synchroniser and history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevQ <= '0;
    end else begin
      syncA <= rawPin;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  assign riseEvt  = syncB & ~prevQ & riseQ;
  assign fallEvt  = ~syncB & prevQ & fallQ;
  assign levelHit = levelQ & ~(syncB ^ riseQ);

  // pending flag storage, set has priority over clear
  if (SPLIT_PENDING != 0) begin : g_split
    logic [LINES-1:0] setRise;
    logic [LINES-1:0] setFall;
    assign setRise = riseEvt | strobes.swSet | (levelHit & riseQ);
    assign setFall = fallEvt | (levelHit & ~riseQ);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendRise <= '0;
        pendFall <= '0;
      end else begin
        pendRise <= (pendRise & ~strobes.clrRise) | setRise;
        pendFall <= (pendFall & ~strobes.clrFall) | setFall;
      end
    end
  end else begin : g_single
    logic [LINES-1:0] setAny;
    logic [LINES-1:0] clrAny;
    assign setAny = riseEvt | fallEvt | strobes.swSet | levelHit;
    assign clrAny = strobes.clrRise | strobes.clrFall;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pendRise <= '0;
      else       pendRise <= (pendRise & ~clrAny) | setAny;
    end
    assign pendFall = '0;
  end

  // masking and grouping
  assign activeReq = (pendRise | pendFall) & maskQ;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
    assign irqOut[g] = |(activeReq & groupLines(g));
  end

endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int NUM_PORTS     = 16,
  parameter int SPLIT_PENDING = 0
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            wrEn,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               wdata,
  output logic [DATA_W-1:0]               rdata,
  input  logic [NUM_PORTS-1:0][LINES-1:0] portPins,
  output logic [NUM_IRQ-1:0]              irqOut
);

  strobe_t                     strobes;
  logic [LINES-1:0]            maskQ;
  logic [LINES-1:0]            riseQ;
  logic [LINES-1:0]            fallQ;
  logic [LINES-1:0]            levelQ;
  logic [LINES-1:0][SEL_W-1:0] selQ;
  logic [LINES-1:0]            pendRise;
  logic [LINES-1:0]            pendFall;
  logic [LINES-1:0]            pendAny;

  assign pendAny = pendRise | pendFall;

  extint_regs #(
    .SPLIT_PENDING(SPLIT_PENDING)
  ) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .addr     (addr),
    .wdata    (wdata),
    .pendRise (pendRise),
    .pendFall (pendFall),
    .rdata    (rdata),
    .strobes  (strobes),
    .maskQ    (maskQ),
    .riseQ    (riseQ),
    .fallQ    (fallQ),
    .levelQ   (levelQ),
    .selQ     (selQ)
  );

  extint_datapath #(
    .NUM_PORTS    (NUM_PORTS),
    .SPLIT_PENDING(SPLIT_PENDING)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .portPins (portPins),
    .selQ     (selQ),
    .maskQ    (maskQ),
    .riseQ    (riseQ),
    .fallQ    (fallQ),
    .levelQ   (levelQ),
    .strobes  (strobes),
    .pendRise (pendRise),
    .pendFall (pendFall),
    .irqOut   (irqOut)
  );

endmodule

// File: rtl/extint_checker.sv
module extint_checker
  import extint_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic [ADDR_W-1:0]    addr,
  input logic [LINES-1:0]     wdataLo,
  input logic [DATA_W-1:LINES] rdataHi,
  input logic [NUM_IRQ-1:0]   irqOut,
  input logic [LINES-1:0]     maskQ,
  input logic [LINES-1:0]     pendAny
);

  // R1: reserved upper bits of the plain registers read zero
  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (addr < 4'd8) |-> (rdataHi == '0));

  // R3: a pending bit only drops after a clear write
  p_clear_needs_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (($past(pendAny) & ~pendAny) != '0) |->
      ($past(wrEn) && ($past(addr) >= 4'd4) && ($past(addr) <= 4'd6)));

  // R5: software trigger leaves every written bit pending
  p_swset_sets_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 4'd3) |=> ((pendAny & $past(wdataLo)) == $past(wdataLo)));

  // R6: clearing the whole mask silences the outputs
  p_mask_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 4'd0 && wdataLo == '0) |=> (irqOut == '0));

  // R6, R8: each dedicated output needs its own line pending and enabled
  for (genvar i = 0; i < SOLO_LINES; i++) begin : g_solo
    p_solo_enable_r8: assert property (@(posedge clk) disable iff (!rstN)
      irqOut[i] |-> (maskQ[i] && pendAny[i]));
  end

  // R8: shared outputs need an enabled pending line inside their group
  p_mid_group_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqOut[SOLO_LINES] |-> ((maskQ[9:5] & pendAny[9:5]) != '0));

  p_high_group_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqOut[SOLO_LINES+1] |-> ((maskQ[15:10] & pendAny[15:10]) != '0));

endmodule

bind extint_ctrl extint_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .addr    (addr),
  .wdataLo (wdata[15:0]),
  .rdataHi (rdata[31:16]),
  .irqOut  (irqOut),
  .maskQ   (maskQ),
  .pendAny (pendAny)
);

// File: tb/test_extint_ctrl.sv
module test_extint_ctrl;

  logic              clk = 1'b0;
  logic              rstN;
  logic              wrEn;
  logic [3:0]        addr;
  logic [31:0]       wdata;
  logic [15:0][15:0] pins;
  logic [31:0]       rdataS, rdataP;
  logic [6:0]        irqS, irqP;
  logic [31:0]       rS, rP;
  int                nChecks = 0;
  int                nFails = 0;
  bit                finished = 1'b0;

  always #5 clk = ~clk;

  extint_ctrl #(.NUM_PORTS(16), .SPLIT_PENDING(0)) i_extint_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .rdata(rdataS), .portPins(pins), .irqOut(irqS));

  extint_ctrl #(.NUM_PORTS(16), .SPLIT_PENDING(1)) i_extint_ctrl_split (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .rdata(rdataP), .portPins(pins), .irqOut(irqP));

  function automatic logic [6:0] expIrq(input logic [15:0] act);
    logic [6:0] v = '0;
    for (int l = 0; l < 16; l++) begin
      if (act[l]) v[(l < 5) ? l : ((l < 10) ? 5 : 6)] = 1'b1;
    end
    return v;
  endfunction

  function automatic logic expEdge(input logic oldV, input logic newV,
                                   input logic r, input logic f);
    return (oldV != newV) && ((newV && r) || (!newV && f));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk);
    addr = a;
    #1;
    rS = rdataS; rP = rdataP;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    rstN = 1'b0; wrEn = 1'b0; addr = '0; wdata = '0; pins = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R12: reset state
    for (int a = 0; a < 12; a++) begin
      rd(4'(a));
      chk("R12 single", rS, 32'h0);
      chk("R12 split", rP, 32'h0);
    end
    chk("R12 irq", {25'b0, irqS, irqP}, 32'h0);

    // R1: upper bits dropped
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0); chk("R1 mask", rS, 32'h0000_FFFF);
    wr(4'd0, 32'h0);

    // R7: packed selector fields
    wr(4'd9, 32'hFFFE_FDFC);
    rd(4'd9); chk("R7 sel readback", rS, 32'h0F0E_0D0C);
    wr(4'd1, 32'h0040); wr(4'd0, 32'h0040); wr(4'd4, 32'hFFFF);
    pins[0][6] = 1'b1; settle();
    rd(4'd4); chk("R7 other port ignored", rS, 32'h0);
    pins[14][6] = 1'b1; settle();
    rd(4'd4); chk("R7 selected port", rS, 32'h0040);
    chk("R8 group 5..9", {25'b0, irqS}, {25'b0, 7'b0100000});
    wr(4'd4, 32'h0040); wr(4'd1, 32'h0); wr(4'd0, 32'h0);

    // R10: latency on line 0, port 0
    wr(4'd1, 32'h1); wr(4'd0, 32'h1);
    @(negedge clk); pins[0][0] = 1'b1; addr = 4'd4;
    @(negedge clk);
    @(negedge clk); #1 chk("R10 not after two edges", rdataS, 32'h0);
    @(negedge clk); #1 chk("R10 after three edges", rdataS, 32'h1);
    chk("R8 line 0 output", {25'b0, irqS}, 32'h1);

    // R3: write-1-to-clear
    wr(4'd4, 32'h0); rd(4'd4); chk("R3 zero write keeps", rS, 32'h1);
    wr(4'd4, 32'h1); rd(4'd4); chk("R3 one write clears", rS, 32'h0);

    // R2: polarity choices on line 0
    wr(4'd1, 32'h0); wr(4'd2, 32'h1);
    pins[0][0] = 1'b0; settle(); rd(4'd4); chk("R2 falling only, fall", rS, 32'h1);
    wr(4'd4, 32'h1);
    pins[0][0] = 1'b1; settle(); rd(4'd4); chk("R2 falling only, rise", rS, 32'h0);
    wr(4'd1, 32'h1);
    pins[0][0] = 1'b0; settle(); rd(4'd4); chk("R2 both, fall", rS, 32'h1);
    wr(4'd4, 32'h1);
    pins[0][0] = 1'b1; settle(); rd(4'd4); chk("R2 both, rise", rS, 32'h1);
    wr(4'd4, 32'h1); wr(4'd1, 32'h0); wr(4'd2, 32'h0);
    pins[0][0] = 1'b0; settle(); pins[0][0] = 1'b1; settle();
    rd(4'd4); chk("R2 neither", rS, 32'h0);

    // R5, R6: software trigger and masking
    wr(4'd0, 32'h0);
    wr(4'd3, 32'h8001);
    rd(4'd4); chk("R5 swset pending", rS, 32'h8001);
    rd(4'd3); chk("R5 swset reads zero", rS, 32'h0);
    chk("R6 masked output", {25'b0, irqS}, 32'h0);
    wr(4'd0, 32'h8000);
    chk("R6 unmasked output", {25'b0, irqS}, {25'b0, 7'b1000000});
    wr(4'd4, 32'h8001); wr(4'd0, 32'h0);

    // R11: set beats clear on line 1
    wr(4'd1, 32'h2); wr(4'd3, 32'h2);
    @(negedge clk); pins[0][1] = 1'b1;
    @(negedge clk);
    @(negedge clk); wrEn = 1'b1; addr = 4'd4; wdata = 32'h2;
    @(negedge clk); wrEn = 1'b0; wdata = '0;
    rd(4'd4); chk("R11 set wins", rS, 32'h2);
    wr(4'd4, 32'h2); rd(4'd4); chk("R11 later clear", rS, 32'h0);
    wr(4'd1, 32'h0);

    // R9: level mode on line 2
    pins[0][2] = 1'b1; settle();
    wr(4'd1, 32'h4); wr(4'd7, 32'h4); settle();
    rd(4'd4); chk("R9 already active", rS, 32'h4);
    wr(4'd4, 32'h4); rd(4'd4); chk("R9 re-armed", rS, 32'h4);
    pins[0][2] = 1'b0; settle(); wr(4'd4, 32'h4); settle();
    rd(4'd4); chk("R9 inactive stays clear", rS, 32'h0);
    wr(4'd1, 32'h0); settle();
    rd(4'd4); chk("R9 active low", rS, 32'h4);
    wr(4'd7, 32'h0); wr(4'd4, 32'h4);
    rd(4'd4); chk("R9 released", rS, 32'h0);

    // R4: split flags on line 3
    wr(4'd1, 32'h8); wr(4'd2, 32'h8);
    pins[0][3] = 1'b1; settle();
    rd(4'd5); chk("R4 rise flag", rP, 32'h8); chk("R4 single addr5 zero", rS, 32'h0);
    rd(4'd6); chk("R4 fall flag idle", rP, 32'h0);
    pins[0][3] = 1'b0; settle();
    rd(4'd6); chk("R4 fall flag", rP, 32'h8);
    wr(4'd5, 32'h8);
    rd(4'd5); chk("R4 rise cleared", rP, 32'h0);
    rd(4'd4); chk("R4 combined split", rP, 32'h8); chk("R4 single ignores addr5", rS, 32'h8);
    wr(4'd6, 32'h8);
    rd(4'd4); chk("R4 both cleared", rP, 32'h0);
    wr(4'd4, 32'h8); wr(4'd1, 32'h0); wr(4'd2, 32'h0);
    rd(4'd4); chk("R4 all idle", rS | rP, 32'h0);

    // R2, R7, R8: random single-line trials
    for (int t = 0; t < 40; t++) begin
      int l, p, q;
      logic r, f, oldV, newV, e;
      logic [31:0] selWord;
      l = int'($urandom % 16); p = int'($urandom % 16); q = (p + 1) % 16;
      r = 1'($urandom); f = 1'($urandom);
      oldV = 1'($urandom); newV = 1'($urandom);
      selWord = '0;
      selWord[(l % 4) * 8 +: 4] = 4'(p);
      wr(4'(8 + l / 4), selWord);
      wr(4'd1, 32'(r) << l); wr(4'd2, 32'(f) << l); wr(4'd0, 32'h1 << l);
      pins[p][l] = oldV; settle();
      wr(4'd4, 32'hFFFF);
      pins[p][l] = newV; pins[q][l] = 1'($urandom); settle();
      e = expEdge(oldV, newV, r, f);
      rd(4'd4);
      chk("R2 random pending", rS, 32'(e) << l);
      chk("R4 random split combined", rP, 32'(e) << l);
      chk("R8 random output", {25'b0, irqS}, {25'b0, expIrq(16'(32'(e) << l))});
    end

    summary();
  end

endmodule